// File: doc/BRIEF.md
# Thermal Monitor Alert Controller

This block is the digital front end of an on-chip temperature monitor. It holds the start/stop control, the operating mode and the sampling cadence. It produces a periodic sample strobe and latches the sensor's 9-bit two's-complement reading on each strobe. Every new reading is compared against three programmable per-channel limits in whole degrees Celsius. A channel whose limit is reached latches a pending flag. The pending flags that are enabled are merged into one interrupt line.

A host reads and writes word registers through a plain single-cycle write strobe and a combinational read port. Software sets up the limits and the interrupt enables, selects the temperature mode and a period code, and then starts the monitor. The block enforces the two timing rules of the sensor. After a start, no sample is taken until a settling interval has passed. After a stop, a new start is refused until a restart lockout has elapsed.

Register word addresses:
- 0: run control, bit 0.
- 1: mode, bits 3:0.
- 2: repeat, bit 24 for endless and bits 3:0 for the period code.
- 3: latest reading, read only.
- 4 to 6: limit registers for channels 0 to 2.
- 7: interrupt control word.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: After reset every register reads 0, `alert_irq` is 0 and `sample_tick` is 0.
- R2: Writing 1 to bit 0 of address 0 starts the monitor, and writing 0 stops it. Bit 0 reads back the run state. A start written within RESTART_CYC cycles after a stop is ignored, and a start written later is accepted.
- R3: After an accepted start, `sample_tick` first rises SETTLE_CYC clock edges after the edge that took the start write. The strobe is only ever high while the monitor runs.
- R4: With bit 24 of address 2 set (endless), strobes repeat every PERIOD_UNIT*(code+1) cycles, where code is bits 3:0 of address 2. With bit 24 clear, exactly one strobe follows each start. Every strobe lasts one cycle.
- R5: Strobes are produced only while the mode field (address 1, bits 3:0) holds 5.
- R6: On each strobe the sensor input is latched. Address 3 returns it sign-extended to 32 bits, and it does not change between strobes.
- R7: Limit registers at addresses 4+ch hold an enable in bit 0 and a signed 8-bit limit in bits 23:16. All other bits read 0.
- R8: On a strobe, channel ch sets its pending flag when all of these hold: its interrupt enable is set, its limit enable is set, and the signed reading is greater than or equal to the sign-extended limit. Otherwise the flag is held.
- R9: In the interrupt control word at address 7, channel ch uses bit 4ch for interrupt enable (read/write) and bit 4ch+1 for pending (read only). Bit 4ch+2 is the clear bit: writing 1 drops the pending flag, and the bit always reads 0.
- R10: If a set and a clear of the same channel fall in the same cycle, the flag ends up set.
- R11: `alert_irq` is the OR over channels of pending AND interrupt enable. It is forced low while the monitor is stopped, and pending flags are kept when the monitor stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sensor_temp | input | 9 | Sensor reading, two's complement whole degrees |
| sample_tick | output | 1 | One-cycle sample strobe |
| alert_irq | output | 1 | Merged alert interrupt |

## Verification
The internal state lies in three places: the run, settle and lockout counters, the latched reading, and the pending flags. Each of them is visible at the ports within one cycle.

A miscounted settle or period counter moves the edge of `sample_tick`, so the bench counts the cycles to each edge exactly. A pending flag that is wrongly set or wrongly kept shows in the read of address 7 and on `alert_irq` right after the capture edge. The bench checks the equal-value and sign-crossing cases of the comparison, and it places a clear write exactly on a capture edge.

// File: rtl/tm_pkg.sv
package tm_pkg;
   // register word indices
   localparam int REG_RUN      = 0;
   localparam int REG_MODE     = 1;
   localparam int REG_REPEAT   = 2;
   localparam int REG_TEMP     = 3;
   localparam int REG_LIM_BASE = 4;

   // field positions that software and the bench rely on
   localparam int MODE_W       = 4;
   localparam int CODE_W       = 4;
   localparam int ENDLESS_BIT  = 24;
   localparam int LIM_LSB      = 16;
   localparam int NIB          = 4;
   localparam int NIB_IEN      = 0;
   localparam int NIB_PEND     = 1;
   localparam int NIB_CLR      = 2;

   localparam logic [MODE_W-1:0] MODE_TEMP = 4'h5;
endpackage

// File: rtl/tm_regs.sv
module tm_regs
   import tm_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int TEMP_W = 9,
   parameter int THR_W  = 8,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [DATA_W-1:0]            wdata,
   output logic [DATA_W-1:0]            rdata,
   input  logic                         run,
   input  logic [TEMP_W-1:0]            temp,
   input  logic [NUM_CH-1:0]            pend,
   output logic                         run_wr,
   output logic                         mode_ok,
   output logic                         endless,
   output logic [CODE_W-1:0]            code,
   output logic [NUM_CH-1:0]            lim_en,
   output logic [NUM_CH-1:0][THR_W-1:0] lim_val,
   output logic [NUM_CH-1:0]            ien,
   output logic [NUM_CH-1:0]            clr
);
   localparam int REG_INT = REG_LIM_BASE + NUM_CH;

   logic [MODE_W-1:0] mode_q;
   logic              hit_run, hit_mode, hit_rep, hit_int;
   logic [NUM_CH-1:0] hit_lim;

   assign hit_run  = wr && (addr == ADDR_W'(REG_RUN));
   assign hit_mode = wr && (addr == ADDR_W'(REG_MODE));
   assign hit_rep  = wr && (addr == ADDR_W'(REG_REPEAT));
   assign hit_int  = wr && (addr == ADDR_W'(REG_INT));
   assign run_wr   = hit_run;
   assign mode_ok  = (mode_q == MODE_TEMP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         endless <= 1'b0;
         code    <= '0;
      end else begin
         if (hit_mode) mode_q <= wdata[MODE_W-1:0];
         if (hit_rep) begin
            endless <= wdata[ENDLESS_BIT];
            code    <= wdata[CODE_W-1:0];
         end
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign hit_lim[ch] = wr && (addr == ADDR_W'(REG_LIM_BASE + ch));
      assign clr[ch]     = hit_int && wdata[NIB*ch + NIB_CLR];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lim_en[ch]  <= 1'b0;
            lim_val[ch] <= '0;
            ien[ch]     <= 1'b0;
         end else begin
            if (hit_lim[ch]) begin
               lim_en[ch]  <= wdata[0];
               lim_val[ch] <= wdata[LIM_LSB +: THR_W];
            end
            if (hit_int) ien[ch] <= wdata[NIB*ch + NIB_IEN];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(REG_RUN)) begin
         rdata[0] = run;
      end else if (addr == ADDR_W'(REG_MODE)) begin
         rdata[MODE_W-1:0] = mode_q;
      end else if (addr == ADDR_W'(REG_REPEAT)) begin
         rdata[ENDLESS_BIT]  = endless;
         rdata[CODE_W-1:0]   = code;
      end else if (addr == ADDR_W'(REG_TEMP)) begin
         rdata = {{(DATA_W-TEMP_W){temp[TEMP_W-1]}}, temp};
      end else if (addr == ADDR_W'(REG_INT)) begin
         for (int ch = 0; ch < NUM_CH; ch++) begin
            rdata[NIB*ch + NIB_IEN]  = ien[ch];
            rdata[NIB*ch + NIB_PEND] = pend[ch];
         end
      end else begin
         for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr == ADDR_W'(REG_LIM_BASE + ch)) begin
               rdata[0]                 = lim_en[ch];
               rdata[LIM_LSB +: THR_W]  = lim_val[ch];
            end
         end
      end
   end

   // R9 clear_reads_zero_chk: a clear bit is never reflected in the read word
   always_comb begin
      if (rst_n && addr == ADDR_W'(REG_INT)) begin
         for (int ch = 0; ch < NUM_CH; ch++)
            clear_reads_zero_chk: assert (rdata[NIB*ch + NIB_CLR] == 1'b0);
      end
   end
endmodule

// File: rtl/tm_sampler.sv
module tm_sampler
   import tm_pkg::*;
#(
   parameter int SETTLE_CYC  = 20,
   parameter int RESTART_CYC = 30,
   parameter int PERIOD_UNIT = 8,
   parameter bit PERIOD_EXP  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_wr,
   input  logic              run_val,
   input  logic              mode_ok,
   input  logic              endless,
   input  logic [CODE_W-1:0] code,
   output logic              run_q,
   output logic              tick
);
   localparam int CODE_MAX   = (1 << CODE_W) - 1;
   localparam int MAX_PERIOD = PERIOD_EXP ? (PERIOD_UNIT << CODE_MAX)
                                          : (PERIOD_UNIT * (CODE_MAX + 1));
   localparam int MAX_CNT    = (MAX_PERIOD > SETTLE_CYC) ? MAX_PERIOD : SETTLE_CYC;
   localparam int CNT_W      = $clog2(MAX_CNT + 1);
   localparam int LOCK_W     = $clog2(RESTART_CYC + 1);

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  interval;
   logic [LOCK_W-1:0] lock_cnt;
   logic              shot_done;
   logic              do_stop, do_start;

   // period table variant chosen at elaboration
   if (PERIOD_EXP) begin : g_exp
      assign interval = CNT_W'(PERIOD_UNIT) << code;
   end else begin : g_lin
      assign interval = CNT_W'(PERIOD_UNIT) * (CNT_W'(code) + CNT_W'(1));
   end

   assign do_stop  = run_wr && !run_val && run_q;
   assign do_start = run_wr &&  run_val && !run_q && (lock_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         cnt       <= '0;
         lock_cnt  <= '0;
         shot_done <= 1'b0;
         tick      <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (lock_cnt != '0) lock_cnt <= lock_cnt - LOCK_W'(1);
         if (do_stop) begin
            run_q    <= 1'b0;
            lock_cnt <= LOCK_W'(RESTART_CYC);
         end else if (do_start) begin
            run_q     <= 1'b1;
            cnt       <= CNT_W'(SETTLE_CYC - 1);
            shot_done <= 1'b0;
         end else if (run_q) begin
            if (cnt == '0) begin
               cnt <= interval - CNT_W'(1);
               if (mode_ok && (endless || !shot_done)) begin
                  tick      <= 1'b1;
                  shot_done <= 1'b1;
               end
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end
      end
   end

   // R2
   restart_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_cnt != '0) |=> !run_q);
   // R3
   tick_while_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run_q);
   // R4
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R5
   mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_ok |=> !tick);
endmodule

// File: rtl/tm_alert_ch.sv
module tm_alert_ch #(
   parameter int TEMP_W = 9,
   parameter int THR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [TEMP_W-1:0] sample,
   input  logic              lim_en,
   input  logic [THR_W-1:0]  lim_val,
   input  logic              ien,
   input  logic              clr,
   output logic              pend
);
   logic signed [TEMP_W-1:0] lim_x;
   logic                     reach;
   logic                     set_req;

   assign lim_x   = {{(TEMP_W-THR_W){lim_val[THR_W-1]}}, lim_val};
   assign reach   = $signed(sample) >= lim_x;
   assign set_req = tick && ien && lim_en && reach;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend <= 1'b0;
      else if (set_req) pend <= 1'b1;
      else if (clr)     pend <= 1'b0;
   end

   // R8
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !tick) |=> !pend);
   // R9
   clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !tick) |=> !pend);
   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && tick && ien && lim_en && reach) |=> pend);
endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
   import tm_pkg::*;
#(
   parameter int NUM_CH      = 3,
   parameter int TEMP_W      = 9,
   parameter int THR_W       = 8,
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 32,
   parameter int SETTLE_CYC  = 20,
   parameter int RESTART_CYC = 30,
   parameter int PERIOD_UNIT = 8,
   parameter bit PERIOD_EXP  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [TEMP_W-1:0] sensor_temp,
   output logic              sample_tick,
   output logic              alert_irq
);
   // elaboration-time parameter checks
   if (NUM_CH * NIB > ENDLESS_BIT)                 $error("NUM_CH too large for control word");
   if (LIM_LSB + THR_W > DATA_W)                   $error("limit field exceeds data width");
   if (THR_W >= TEMP_W)                            $error("limit must be narrower than reading");
   if (TEMP_W > DATA_W || ENDLESS_BIT >= DATA_W)   $error("data width too small");
   if (REG_LIM_BASE + NUM_CH >= (1 << ADDR_W))     $error("address space too small");
   if (SETTLE_CYC < 1 || RESTART_CYC < 1)          $error("timing counts must be positive");
   if (PERIOD_UNIT < 2)                            $error("PERIOD_UNIT must be at least 2");

   logic                         run, run_wr, mode_ok, endless;
   logic [CODE_W-1:0]            code;
   logic [NUM_CH-1:0]            lim_en, ien, clr, pend;
   logic [NUM_CH-1:0][THR_W-1:0] lim_val;
   logic [TEMP_W-1:0]            temp_q;

   tm_regs #(
      .NUM_CH(NUM_CH), .TEMP_W(TEMP_W), .THR_W(THR_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .run(run), .temp(temp_q),
      .pend(pend), .run_wr(run_wr), .mode_ok(mode_ok), .endless(endless),
      .code(code), .lim_en(lim_en), .lim_val(lim_val), .ien(ien), .clr(clr)
   );

   tm_sampler #(
      .SETTLE_CYC(SETTLE_CYC), .RESTART_CYC(RESTART_CYC),
      .PERIOD_UNIT(PERIOD_UNIT), .PERIOD_EXP(PERIOD_EXP)
   ) u_sampler (
      .clk(clk), .rst_n(rst_n), .run_wr(run_wr), .run_val(bus_wdata[0]),
      .mode_ok(mode_ok), .endless(endless), .code(code),
      .run_q(run), .tick(sample_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           temp_q <= '0;
      else if (sample_tick) temp_q <= sensor_temp;
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_alert
      tm_alert_ch #(.TEMP_W(TEMP_W), .THR_W(THR_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(sample_tick), .sample(sensor_temp),
         .lim_en(lim_en[ch]), .lim_val(lim_val[ch]), .ien(ien[ch]),
         .clr(clr[ch]), .pend(pend[ch])
      );
   end

   assign alert_irq = run && |(pend & ien);

   // R6
   sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> $stable(temp_q));
   // R11
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !alert_irq);
endmodule

// File: tb/tb_thermal_alert_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_alert_ctrl;
   localparam int SETTLE  = 20;
   localparam int RESTART = 30;
   localparam int UNIT    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [8:0]  sensor_temp = '0;
   logic        sample_tick;
   logic        alert_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   thermal_alert_ctrl #(
      .SETTLE_CYC(SETTLE), .RESTART_CYC(RESTART), .PERIOD_UNIT(UNIT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sensor_temp(sensor_temp),
      .sample_tick(sample_tick), .alert_irq(alert_irq)
   );

   // {sample[8:0], lim0[7:0], lim1[7:0], lim2[7:0], expected pending[2:0]}
   localparam logic [35:0] VEC [6] = '{
      {9'd50,   8'd40,  8'd50,  8'd60,  3'b011},
      {9'h1F6,  8'hEC,  8'hF6,  8'h00,  3'b011},
      {9'd127,  8'd127, 8'h80,  8'd100, 3'b111},
      {9'h138,  8'h80,  8'h00,  8'd127, 3'b000},
      {9'h0C8,  8'd127, 8'hFF,  8'd5,   3'b111},
      {9'h1FF,  8'hFF,  8'h00,  8'hFE,  3'b101}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cycles_to_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sample_tick && n < 1000);
   endtask

   task automatic count_ticks(input int span, output int n);
      n = 0;
      for (int i = 0; i < span; i++) begin
         @(negedge clk);
         if (sample_tick) n++;
      end
   endtask

   initial begin
      logic [31:0] d;
      int n;
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check("R1 register reset", d, 32'h0);
      end
      check("R1 irq reset", {31'b0, alert_irq}, 32'h0);
      check("R1 tick reset", {31'b0, sample_tick}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 limit register fields
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, d);
      check("R7 limit readback", d, 32'h00FF_0001);
      // R9 control word: enables stick, clear bits read 0, pending 0
      wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd7, d);
      check("R9 control word readback", d, 32'h0000_0111);
      wr(3'd7, 32'h0);
      wr(3'd4, 32'h0);
      wr(3'd2, 32'hFFFF_FFF3);
      rd(3'd2, d);
      check("R4 repeat readback", d, 32'h0100_0003);

      // R5 no strobes with wrong mode
      wr(3'd1, 32'h0000_0004);
      wr(3'd0, 32'h1);
      count_ticks(SETTLE + 80, n);
      check("R5 no tick in wrong mode", n, 0);
      rd(3'd3, d);
      check("R5 reading untouched", d, 32'h0);

      // R2 stop then immediate restart ignored
      wr(3'd0, 32'h0);
      wr(3'd0, 32'h1);
      rd(3'd0, d);
      check("R2 start ignored in lockout", d, 32'h0);
      idle(RESTART + 2);
      wr(3'd1, 32'h0000_0005);
      wr(3'd2, 32'h0100_0002);
      wr(3'd0, 32'h1);
      rd(3'd0, d);
      check("R2 start accepted after lockout", d, 32'h1);
      // R3 settle interval
      cycles_to_tick(n);
      check("R3 first tick after settle", n, SETTLE);
      // R4 endless period for code 2
      cycles_to_tick(n);
      check("R4 endless period code 2", n, UNIT * 3);
      cycles_to_tick(n);
      check("R4 endless period repeats", n, UNIT * 3);

      // vector walk: R6, R8, R11 with code 3 period
      wr(3'd0, 32'h0);
      idle(RESTART + 2);
      wr(3'd2, 32'h0100_0003);
      wr(3'd7, 32'h0000_0111);
      wr(3'd0, 32'h1);
      cycles_to_tick(n);
      @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         logic [35:0] v;
         v = VEC[i];
         wr(3'd4, {8'h0, v[26:19], 15'h0, 1'b1});
         wr(3'd5, {8'h0, v[18:11], 15'h0, 1'b1});
         wr(3'd6, {8'h0, v[10:3],  15'h0, 1'b1});
         sensor_temp = v[35:27];
         wr(3'd7, 32'h0000_0555);
         cycles_to_tick(n);
         @(negedge clk);
         rd(3'd7, d);
         check("R8 pending after compare", {29'b0, d[9], d[5], d[1]}, {29'b0, v[2:0]});
         rd(3'd3, d);
         check("R6 captured reading", d, {{23{v[35]}}, v[35:27]});
         check("R11 irq follows pending", {31'b0, alert_irq}, {31'b0, |v[2:0]});
      end

      // R11 stop forces irq low, pending kept
      wr(3'd0, 32'h0);
      check("R11 irq low when stopped", {31'b0, alert_irq}, 32'h0);
      rd(3'd7, d);
      check("R11 pending kept when stopped", d, 32'h0000_0313);

      // R6 no capture while stopped
      sensor_temp = 9'h055;
      idle(60);
      rd(3'd3, d);
      check("R6 reading held while stopped", d, 32'hFFFF_FFFF);
      sensor_temp = 9'h1FF;

      // R10 set wins over clear on the capture edge
      idle(RESTART);
      wr(3'd7, 32'h0000_0555);
      rd(3'd7, d);
      check("R9 clear drops pending", d, 32'h0000_0111);
      wr(3'd0, 32'h1);
      cycles_to_tick(n);
      wr(3'd7, 32'h0000_0555);
      rd(3'd7, d);
      check("R10 set beats clear", d, 32'h0000_0313);
      wr(3'd7, 32'h0000_0555);
      rd(3'd7, d);
      check("R9 clear after collision", d, 32'h0000_0111);
      check("R11 irq low after clear", {31'b0, alert_irq}, 32'h0);

      // R4 one-shot mode
      wr(3'd0, 32'h0);
      idle(RESTART + 2);
      wr(3'd2, 32'h0000_0000);
      wr(3'd0, 32'h1);
      count_ticks(SETTLE + 200, n);
      check("R4 one-shot single tick", n, 1);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule